// File: doc/BRIEF.md
# Programmable Bidirectional I/O Cell

A configurable cell that sits between one pad and the on-chip routing. Static configuration inputs choose how the pad is used. As an input, the pad value reaches the routing either straight through, through an edge-triggered register, or through a level-sensitive latch. As an output, the pad is driven from a logic-cell signal whose polarity can be inverted. In bidirectional use, the driver enable comes from a local product-term enable or from one of two chip-wide enables.

The register and the latch share one I/O clock. That clock is picked from two clock lines, and both storage elements clear asynchronously on an active-low reset. The cell does not model the pad itself. It presents a value and an enable to the pad ring and receives the resolved pad level back, so the caller builds the tri-state node.

Top module: `pio_cell`

## Requirements
- R1: Mode codes 0, 5, 6 and 7 on `mode_i` select combinational input: `route_o` equals `pad_i` in the same cycle.
- R2: Mode code 1 selects registered input: `route_o` shows the `pad_i` value captured at the last rising edge of the selected I/O clock.
- R3: Mode code 2 selects latched input: `route_o` follows `pad_i` while the selected I/O clock is high, and holds the last such value while it is low.
- R4: Mode code 3 is output-only. The driver is always enabled, and `route_o` is held at 0 whatever the pad level.
- R5: Mode code 4 is bidirectional. `route_o` equals `pad_i`, so the cell reads back its own driven level when enabled.
- R6: In bidirectional mode, `oe_sel_i` picks the driver enable: 0 or 3 selects `pt_oe_i`, 1 selects `goe_a_i`, 2 selects `goe_b_i`.
- R7: `pad_o` equals `core_d_i` when `inv_i` is 0 and its complement when `inv_i` is 1.
- R8: `clk_sel_i` = 0 makes `clk_a_i` the I/O clock, and `clk_sel_i` = 1 makes `clk_b_i` the I/O clock.
- R9: `rst_ni` low clears the input register and the input latch to 0 at once, without waiting for a clock edge.
- R10: In every input-only mode (codes 0, 1, 2, 5, 6, 7), `pad_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | I/O clock line A |
| clk_b_i | input | 1 | I/O clock line B |
| rst_ni | input | 1 | Active-low asynchronous clear of register and latch |
| mode_i | input | 3 | Cell mode code |
| clk_sel_i | input | 1 | I/O clock line select |
| inv_i | input | 1 | Output polarity invert |
| oe_sel_i | input | 2 | Driver enable source select |
| core_d_i | input | 1 | Logic-cell output to drive |
| pt_oe_i | input | 1 | Local product-term enable |
| goe_a_i | input | 1 | Global output enable A |
| goe_b_i | input | 1 | Global output enable B |
| pad_i | input | 1 | Resolved pad level |
| pad_o | output | 1 | Value presented to the pad driver |
| pad_oe_o | output | 1 | Pad driver enable |
| route_o | output | 1 | Input path result to routing |

## Verification
The hardest cases to reach are the latch holding a value across a falling clock, and the register capturing from the slower clock line. Both happen at times that never line up with the fast bench clock. To reach them, the bench runs the two clock lines at unrelated periods and offsets their edges from the bench's own drive and sample points. It changes the pad level on every cycle, and it switches the clock select and asserts reset while the register and latch modes are active. An external driver always drives the pad when the cell's enable is expected low. This keeps the read-back checks meaningful, and the bench flags any cycle in which both sides drive the pad together.

// File: rtl/pio_pkg.sv
`timescale 1ns/100ps
package pio_pkg;
  localparam int MODE_W  = 3;
  localparam int OESEL_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_COMB  = 3'd0,
    MODE_REG   = 3'd1,
    MODE_LAT   = 3'd2,
    MODE_OUT   = 3'd3,
    MODE_BIDIR = 3'd4
  } pio_mode_e;

  typedef enum logic [OESEL_W-1:0] {
    OE_LOCAL     = 2'd0,
    OE_GLOB_A    = 2'd1,
    OE_GLOB_B    = 2'd2,
    OE_LOCAL_ALT = 2'd3
  } oe_src_e;
endpackage

// File: rtl/pio_clk_sel.sv
`timescale 1ns/100ps
module pio_clk_sel (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_i,
  output logic clk_o
);
  assign clk_o = sel_i ? clk_b_i : clk_a_i;
endmodule

// File: rtl/pio_in_path.sv
`timescale 1ns/100ps
module pio_in_path
  import pio_pkg::*;
#(
  parameter logic CLR_VAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pad_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              route_o
);
  logic reg_q;
  logic lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= CLR_VAL;
    else         reg_q <= pad_i;
  end

  // transparent while io clock high
  always_latch begin
    if (!rst_ni)    lat_q = CLR_VAL;
    else if (clk_i) lat_q = pad_i;
  end

  always_comb begin
    case (mode_i)
      MODE_REG: route_o = reg_q;
      MODE_LAT: route_o = lat_q;
      MODE_OUT: route_o = 1'b0;
      default:  route_o = pad_i;  // comb, bidir, reserved codes
    endcase
  end
endmodule

// File: rtl/pio_out_path.sv
`timescale 1ns/100ps
module pio_out_path
  import pio_pkg::*;
(
  input  logic               core_d_i,
  input  logic               inv_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [OESEL_W-1:0] oe_sel_i,
  input  logic               pt_oe_i,
  input  logic               goe_a_i,
  input  logic               goe_b_i,
  output logic               pad_o,
  output logic               pad_oe_o
);
  logic sel_oe;

  always_comb begin
    case (oe_sel_i)
      OE_GLOB_A: sel_oe = goe_a_i;
      OE_GLOB_B: sel_oe = goe_b_i;
      default:   sel_oe = pt_oe_i;
    endcase
  end

  always_comb begin
    case (mode_i)
      MODE_OUT:   pad_oe_o = 1'b1;
      MODE_BIDIR: pad_oe_o = sel_oe;
      default:    pad_oe_o = 1'b0;
    endcase
  end

  assign pad_o = core_d_i ^ inv_i;
endmodule

// File: rtl/pio_cell.sv
`timescale 1ns/100ps
module pio_cell
  import pio_pkg::*;
#(
  parameter logic CLR_VAL = 1'b0
) (
  input  logic               clk_a_i,
  input  logic               clk_b_i,
  input  logic               rst_ni,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               clk_sel_i,
  input  logic               inv_i,
  input  logic [OESEL_W-1:0] oe_sel_i,
  input  logic               core_d_i,
  input  logic               pt_oe_i,
  input  logic               goe_a_i,
  input  logic               goe_b_i,
  input  logic               pad_i,
  output logic               pad_o,
  output logic               pad_oe_o,
  output logic               route_o
);
  logic io_clk;

  pio_clk_sel u_clk_sel (
    .clk_a_i (clk_a_i),
    .clk_b_i (clk_b_i),
    .sel_i   (clk_sel_i),
    .clk_o   (io_clk)
  );

  pio_in_path #(.CLR_VAL(CLR_VAL)) u_in (
    .clk_i   (io_clk),
    .rst_ni  (rst_ni),
    .pad_i   (pad_i),
    .mode_i  (mode_i),
    .route_o (route_o)
  );

  pio_out_path u_out (
    .core_d_i (core_d_i),
    .inv_i    (inv_i),
    .mode_i   (mode_i),
    .oe_sel_i (oe_sel_i),
    .pt_oe_i  (pt_oe_i),
    .goe_a_i  (goe_a_i),
    .goe_b_i  (goe_b_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );
endmodule

// File: rtl/pio_cell_sva.sv
`timescale 1ns/100ps
module pio_cell_sva
  import pio_pkg::*;
(
  input logic               clk_a_i,
  input logic               rst_ni,
  input logic [MODE_W-1:0]  mode_i,
  input logic               clk_sel_i,
  input logic [OESEL_W-1:0] oe_sel_i,
  input logic               goe_a_i,
  input logic               pad_i,
  input logic               pad_oe_o,
  input logic               route_o
);
  a_r2_reg_capture: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_i == MODE_REG && $past(mode_i) == MODE_REG &&
     !clk_sel_i && !$past(clk_sel_i)) |-> route_o == $past(pad_i));

  a_r4_out_forced: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mode_i == MODE_OUT) |-> (pad_oe_o && !route_o));

  a_r5_bidir_readback: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mode_i == MODE_BIDIR) |-> route_o == pad_i);

  a_r6_goe_a_sel: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mode_i == MODE_BIDIR && oe_sel_i == OE_GLOB_A) |-> pad_oe_o == goe_a_i);

  a_r10_input_hiz: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mode_i != MODE_OUT && mode_i != MODE_BIDIR) |-> !pad_oe_o);
endmodule

bind pio_cell pio_cell_sva u_sva (
  .clk_a_i   (clk_a_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .clk_sel_i (clk_sel_i),
  .oe_sel_i  (oe_sel_i),
  .goe_a_i   (goe_a_i),
  .pad_i     (pad_i),
  .pad_oe_o  (pad_oe_o),
  .route_o   (route_o)
);

// File: tb/pio_cell_bench.sv
`timescale 1ns/100ps
module pio_cell_bench;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b1;
  logic [2:0] mode = 3'd1;
  logic clk_sel = 1'b0;
  logic inv = 1'b0;
  logic [1:0] oe_sel = 2'd0;
  logic core_d = 1'b0, pt_oe = 1'b0, goe_a = 1'b0, goe_b = 1'b0;
  logic ext_en = 1'b1, ext_val = 1'b0;
  logic pad_o, pad_oe, route;
  wire  pad;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_a = ~clk_a;                      // 250 MHz
  initial begin #1; forever #6 clk_b = ~clk_b; end

  assign pad = pad_oe ? pad_o : 1'bz;
  assign pad = ext_en ? ext_val : 1'bz;

  pio_cell u_pio_cell (
    .clk_a_i (clk_a), .clk_b_i (clk_b), .rst_ni (rst_n),
    .mode_i (mode), .clk_sel_i (clk_sel), .inv_i (inv), .oe_sel_i (oe_sel),
    .core_d_i (core_d), .pt_oe_i (pt_oe), .goe_a_i (goe_a), .goe_b_i (goe_b),
    .pad_i (pad), .pad_o (pad_o), .pad_oe_o (pad_oe), .route_o (route)
  );

  // behavioural reference
  wire sel_clk = clk_sel ? clk_b : clk_a;
  logic m_reg = 1'b0;
  logic m_lat = 1'b0;
  always @(posedge sel_clk or negedge rst_n)
    if (!rst_n) m_reg <= 1'b0; else m_reg <= pad;
  always_latch
    if (!rst_n) m_lat = 1'b0; else if (sel_clk) m_lat = pad;

  function automatic logic exp_oe();
    if (mode == 3'd3) return 1'b1;
    if (mode != 3'd4) return 1'b0;
    if (oe_sel == 2'd1) return goe_a;
    if (oe_sel == 2'd2) return goe_b;
    return pt_oe;
  endfunction

  function automatic logic exp_route();
    case (mode)
      3'd1: return m_reg;
      3'd2: return m_lat;
      3'd3: return 1'b0;
      default: return pad;
    endcase
  endfunction

  task automatic check_one(input bit ok, input string tag, input string what,
                           input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b (mode %0d clk_sel %0b t=%0t)",
               tag, what, act, exp, mode, clk_sel, $time);
    end
  endtask

  task automatic check_all();
    string rt, ot;
    logic er, eo;
    er = exp_route();
    eo = exp_oe();
    if (!rst_n)            rt = "R9";
    else if (mode == 3'd1) rt = clk_sel ? "R8" : "R2";
    else if (mode == 3'd2) rt = "R3";
    else if (mode == 3'd3) rt = "R4";
    else if (mode == 3'd4) rt = "R5";
    else                   rt = "R1";
    ot = (mode == 3'd4) ? "R6" : (mode == 3'd3) ? "R4" : "R10";
    check_one(route === er, rt, "route", route, er);
    check_one(pad_oe === eo, ot, "oe", pad_oe, eo);
    if (eo) check_one(pad_o === (core_d ^ inv), "R7", "pad_o", pad_o, core_d ^ inv);
    check_one(!(pad_oe && ext_en), "R10", "contention", pad_oe & ext_en, 1'b0);
  endtask

  task automatic drive_rand();
    core_d  = 1'($urandom);
    inv     = 1'($urandom);
    pt_oe   = 1'($urandom);
    goe_a   = 1'($urandom);
    goe_b   = 1'($urandom);
    ext_val = 1'($urandom);
    if (mode == 3'd4) oe_sel = 2'($urandom);
    ext_en  = !exp_oe();
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_a); #0.5;
      check_all();
      drive_rand();
    end
  endtask

  initial begin
    // reset state: register mode, r9_ clear while reset held
    #1 rst_n = 1'b0;
    step(4);
    @(negedge clk_a); #0.5 rst_n = 1'b1;
    for (int m = 0; m < 8; m++) begin
      for (int cs = 0; cs < 2; cs++) begin
        mode = 3'(m);
        clk_sel = cs[0];
        ext_en = !exp_oe();
        step(40);
        if (m == 1 || m == 2) begin
          // asynchronous clear mid-run (R9)
          rst_n = 1'b0;
          step(3);
          rst_n = 1'b1;
          step(10);
        end
      end
    end
    // clock select switched on the fly in register mode (R8)
    mode = 3'd1;
    for (int k = 0; k < 6; k++) begin
      clk_sel = ~clk_sel;
      step(7);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule